// File: doc/BRIEF.md
# Removable Card SPI-Mode Protocol Engine

This block is the card-side front end of a removable memory card that powers up in its native bit-serial bus mode and can be switched to a byte-oriented SPI mode. The choice is made exactly once: when the first reset command (index 0) completes after power-on, the level of chip select across that frame decides the mode. Once chosen, the mode holds until the active-low power-on reset. Only that reset can clear it.

In SPI mode the engine collects six-byte command frames, answers every frame with a one-byte status (R1) and runs single-block transfers against a simple byte-wide memory port. On a read it sends a start token followed by the block, or, if the memory flags a fault on the first fetch, a one-byte error token in place of the block. On a write it takes the block after the host's start token, skips two check bytes, then returns a data-response token followed by a short busy period. The native-mode protocol itself, CRC checking and the storage array lie outside the block.

The serial pins are oversampled in the system clock domain. SCK must stay high and low for at least five system clocks each. Memory read data is expected one clock after a read strobe.

Top module: `card_spi_frontend`

## Requirements
- R1: After power-on reset both mode outputs are 0, MISO is 1 and no memory strobe is active.
- R2: A command frame with index 0 received while CS is held low throughout, as the first such frame since reset, puts the block in SPI mode (spi_mode_o=1). The R1 byte 0x01 goes out in the byte that immediately follows the frame.
- R3: If that first index-0 frame arrives with CS high, the block sends nothing back (MISO stays 1), sets native_mode_o and then ignores all later traffic, including index-0 frames with CS low. Once SPI mode is chosen, an index-0 frame only answers 0x01 and leaves the block in SPI mode.
- R4: Traffic is whole bytes, MSB first, sampled on rising SCK. The bit count restarts at each falling edge of CS, so a partial byte left before deselection has no effect. MISO changes after falling SCK and reads 0xFF when nothing is due.
- R5: A frame is byte 0 = 01 followed by a 6-bit index, then a 32-bit argument MSB first, then one check byte that is ignored. In SPI mode every frame gets an R1 byte with bit 7 = 0 in the very next byte. An unsupported index sets bit 2 (illegal), giving 0x04 OR the idle bit 0.
- R6: Index 1 clears the idle flag and answers 0x00. After that the idle bit stays 0 in every R1 until another index-0 frame.
- R7: Index 17 reads blk_len bytes starting at the address in the argument. The response is R1 0x00, then 0xFE, then the bytes from consecutive addresses, then 0xFF.
- R8: If the memory raises mem_err_i on the first fetch of a read, error token 0x02 is sent in place of 0xFE and no data byte follows.
- R9: Index 24 waits for the host's 0xFE, writes blk_len bytes to consecutive addresses and ignores two check bytes. It then sends 0x05 (pattern xxx0sss1 with sss=010, accepted), followed by BUSY_BYTES bytes of 0x00, then 0xFF.
- R10: Index 16 sets blk_len to its argument when the argument is between 1 and SECTOR_BYTES, and also equal to SECTOR_BYTES unless PARTIAL_EN=1. Any other argument answers 0x40 (bit 6, parameter) and leaves blk_len unchanged. blk_len resets to SECTOR_BYTES.
- R11: A read or write whose argument + blk_len exceeds MEM_BYTES answers 0x20 (bit 5, address). It sends no token and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sck_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| spi_mode_o | output | 1 | SPI mode latched |
| native_mode_o | output | 1 | Native mode latched |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | $clog2(MEM_BYTES) | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Read data, valid one clock after mem_rd_o |
| mem_err_i | input | 1 | Read fault flag, valid with mem_rdata_i |

## Verification
The bench builds the engine with SECTOR_BYTES=8, MEM_BYTES=64, BUSY_BYTES=2 and PARTIAL_EN=1. These sizes keep full-sector reads short, so the top of the address space is reachable in a few commands. That allows reads that end exactly at the last address and reads that overrun it by one byte. Partial lengths can be set, and both rejected lengths are tried: a zero-byte length and one byte over the sector. A power cycle in the middle of the run lets both mode outcomes be exercised from a fresh start.

// File: rtl/card_spi_pkg.sv
package card_spi_pkg;
  typedef enum logic [1:0] {MODE_UNSET, MODE_NATIVE, MODE_SPI} mode_e;
  typedef enum logic [2:0] {
    ST_CMD, ST_RD_TOK, ST_RD_DATA, ST_WR_TOK, ST_WR_DATA, ST_WR_CRC, ST_WR_BUSY
  } st_e;

  localparam logic [7:0] BYTE_IDLE  = 8'hFF;
  localparam logic [7:0] TOK_START  = 8'hFE;
  localparam logic [7:0] TOK_RD_ERR = 8'h02;
  localparam logic [7:0] TOK_WR_OK  = 8'h05;

  localparam logic [5:0] IDX_RESET  = 6'd0;
  localparam logic [5:0] IDX_INIT   = 6'd1;
  localparam logic [5:0] IDX_BLKLEN = 6'd16;
  localparam logic [5:0] IDX_READ   = 6'd17;
  localparam logic [5:0] IDX_WRITE  = 6'd24;

  localparam int ST_BIT_IDLE  = 0;
  localparam int ST_BIT_ILLEG = 2;
  localparam int ST_BIT_ADDR  = 5;
  localparam int ST_BIT_PARAM = 6;
endpackage

// File: rtl/card_spi_phy.sv
module card_spi_phy (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  input  logic       active_i,
  input  logic [7:0] tx_byte_i,
  output logic       cs_low_o,
  output logic       byte_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       miso_o
);
  logic [2:0] sck_s;
  logic [1:0] cs_s, mosi_s;
  logic       cs_d;
  logic [2:0] bit_cnt;
  logic [7:0] rx_q, tx_q;
  logic       sck_rise, sck_fall, cs_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_s  <= '0;
      cs_s   <= '0;
      mosi_s <= '1;
      cs_d   <= 1'b0;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      cs_s   <= {cs_s[0], ~cs_ni};
      mosi_s <= {mosi_s[0], mosi_i};
      cs_d   <= cs_s[1];
    end
  end

  assign sck_rise = sck_s[1] & ~sck_s[2];
  assign sck_fall = ~sck_s[1] & sck_s[2];
  assign cs_fall  = cs_s[1] & ~cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt      <= '0;
      rx_q         <= '0;
      tx_q         <= '1;
      byte_valid_o <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      if (cs_fall) begin
        bit_cnt <= '0;
        tx_q    <= '1;
      end else if (active_i) begin
        if (sck_rise) begin
          rx_q    <= {rx_q[6:0], mosi_s[1]};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) byte_valid_o <= 1'b1;
        end
        if (sck_fall) begin
          // byte boundary: next byte goes out whole
          if (bit_cnt == 3'd0) tx_q <= tx_byte_i;
          else                 tx_q <= {tx_q[6:0], 1'b1};
        end
      end
    end
  end

  assign cs_low_o  = cs_s[1];
  assign rx_byte_o = rx_q;
  assign miso_o    = tx_q[7];

  // R4
  byte_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);
  // R4
  sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> miso_o);
endmodule

// File: rtl/card_spi_ctrl.sv
module card_spi_ctrl
  import card_spi_pkg::*;
#(
  parameter int SECTOR_BYTES = 8,
  parameter int MEM_BYTES    = 64,
  parameter int BUSY_BYTES   = 2,
  parameter bit PARTIAL_EN   = 1'b1,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int CW = $clog2(((SECTOR_BYTES > BUSY_BYTES) ? SECTOR_BYTES : BUSY_BYTES) + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_low_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    rx_byte_i,
  output logic [7:0]    tx_byte_o,
  output mode_e         mode_o,
  output logic          mem_rd_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  input  logic          mem_err_i
);
  localparam logic [CW-1:0] ONE = CW'(1);

  mode_e          mode_q;
  st_e            st_q;
  logic [2:0]     fcnt_q;
  logic [5:0]     idx_q;
  logic [31:0]    arg_q;
  logic           cs_all_q, idle_q;
  logic [CW-1:0]  blk_len_q, cnt_q;
  logic [AW-1:0]  base_q, addr_q;
  logic [7:0]     tx_q, rd_buf_q, wdata_q;
  logic           rd_pend_q, rd_err_q, mem_rd_q, mem_we_q;

  logic           abort, frame_done, range_bad, len_ok;
  logic           do_rd, do_wr, set_len, clr_idle;
  logic [7:0]     r1_c;

  assign abort      = (mode_q == MODE_SPI) && !cs_low_i;
  assign frame_done = byte_valid_i && !abort && st_q == ST_CMD && fcnt_q == 3'd5;

  assign range_bad = ({1'b0, arg_q} + {{(33-CW){1'b0}}, blk_len_q}) > 33'(MEM_BYTES);
  assign len_ok    = (arg_q != 32'd0) && (arg_q <= 32'(SECTOR_BYTES)) &&
                     (PARTIAL_EN || arg_q == 32'(SECTOR_BYTES));

  always_comb begin
    r1_c = '0; do_rd = 1'b0; do_wr = 1'b0; set_len = 1'b0; clr_idle = 1'b0;
    case (idx_q)
      IDX_RESET:  ;
      IDX_INIT:   clr_idle = 1'b1;
      IDX_BLKLEN: if (len_ok) set_len = 1'b1; else r1_c[ST_BIT_PARAM] = 1'b1;
      IDX_READ:   if (range_bad) r1_c[ST_BIT_ADDR] = 1'b1; else do_rd = 1'b1;
      IDX_WRITE:  if (range_bad) r1_c[ST_BIT_ADDR] = 1'b1; else do_wr = 1'b1;
      default:    r1_c[ST_BIT_ILLEG] = 1'b1;
    endcase
    r1_c[ST_BIT_IDLE] = (idx_q == IDX_RESET) ? 1'b1 : (clr_idle ? 1'b0 : idle_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_UNSET;  st_q <= ST_CMD;   fcnt_q <= '0;
      idx_q <= '0;           arg_q <= '0;      cs_all_q <= 1'b0;
      idle_q <= 1'b1;        blk_len_q <= CW'(SECTOR_BYTES);
      cnt_q <= '0;           base_q <= '0;     addr_q <= '0;
      tx_q <= BYTE_IDLE;     rd_buf_q <= '0;   wdata_q <= '0;
      rd_pend_q <= 1'b0;     rd_err_q <= 1'b0;
      mem_rd_q <= 1'b0;      mem_we_q <= 1'b0;
    end else begin
      mem_rd_q  <= 1'b0;
      mem_we_q  <= 1'b0;
      rd_pend_q <= mem_rd_q;
      if (rd_pend_q) begin
        rd_buf_q <= mem_rdata_i;
        rd_err_q <= mem_err_i;
      end
      if (fcnt_q != 3'd0) cs_all_q <= cs_all_q & cs_low_i;
      if (abort) begin
        st_q   <= ST_CMD;
        fcnt_q <= '0;
      end else if (byte_valid_i) begin
        tx_q <= BYTE_IDLE;
        case (st_q)
          ST_CMD: begin
            if (fcnt_q == 3'd0) begin
              if (rx_byte_i[7:6] == 2'b01) begin
                idx_q    <= rx_byte_i[5:0];
                fcnt_q   <= 3'd1;
                cs_all_q <= cs_low_i;
              end
            end else if (fcnt_q != 3'd5) begin
              arg_q  <= {arg_q[23:0], rx_byte_i};
              fcnt_q <= fcnt_q + 3'd1;
            end else begin
              fcnt_q <= '0;
              if (mode_q == MODE_UNSET && idx_q == IDX_RESET) begin
                if (cs_all_q) begin
                  mode_q <= MODE_SPI;
                  idle_q <= 1'b1;
                  tx_q   <= r1_c;
                end else begin
                  mode_q <= MODE_NATIVE;
                end
              end else if (mode_q == MODE_SPI) begin
                tx_q <= r1_c;
                if (idx_q == IDX_RESET) idle_q <= 1'b1;
                if (clr_idle) idle_q <= 1'b0;
                if (set_len) blk_len_q <= CW'(arg_q);
                if (do_rd || do_wr) begin
                  base_q <= arg_q[AW-1:0];
                  cnt_q  <= '0;
                end
                if (do_rd) begin
                  addr_q   <= arg_q[AW-1:0];
                  mem_rd_q <= 1'b1;
                  st_q     <= ST_RD_TOK;
                end
                if (do_wr) st_q <= ST_WR_TOK;
              end
            end
          end
          ST_RD_TOK: begin
            if (rd_err_q) begin
              tx_q <= TOK_RD_ERR;
              st_q <= ST_CMD;
            end else begin
              tx_q <= TOK_START;
              st_q <= ST_RD_DATA;
            end
          end
          ST_RD_DATA: begin
            tx_q <= rd_buf_q;
            if (cnt_q + ONE == blk_len_q) begin
              st_q <= ST_CMD;
            end else begin
              cnt_q    <= cnt_q + ONE;
              addr_q   <= base_q + AW'(cnt_q + ONE);
              mem_rd_q <= 1'b1;
            end
          end
          ST_WR_TOK: if (rx_byte_i == TOK_START) st_q <= ST_WR_DATA;
          ST_WR_DATA: begin
            mem_we_q <= 1'b1;
            addr_q   <= base_q + AW'(cnt_q);
            wdata_q  <= rx_byte_i;
            if (cnt_q + ONE == blk_len_q) begin
              st_q  <= ST_WR_CRC;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
          ST_WR_CRC: begin
            if (cnt_q == ONE) begin
              tx_q  <= TOK_WR_OK;
              st_q  <= ST_WR_BUSY;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
          ST_WR_BUSY: begin
            if (cnt_q == CW'(BUSY_BYTES)) begin
              st_q <= ST_CMD;
            end else begin
              tx_q  <= 8'h00;
              cnt_q <= cnt_q + ONE;
            end
          end
          default: st_q <= ST_CMD;
        endcase
      end
    end
  end

  assign tx_byte_o   = tx_q;
  assign mode_o      = mode_q;
  assign mem_rd_o    = mem_rd_q;
  assign mem_we_o    = mem_we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  // R3
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_UNSET) |=> (mode_q == $past(mode_q)));
  // R5
  r1_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && mode_q == MODE_SPI) |=> !tx_q[7]);
  // R3
  native_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_SPI) |-> !(mem_rd_q || mem_we_q));
  // R11
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_q && mem_we_q));
endmodule

// File: rtl/card_spi_frontend.sv
module card_spi_frontend
  import card_spi_pkg::*;
#(
  parameter int SECTOR_BYTES = 8,
  parameter int MEM_BYTES    = 64,
  parameter int BUSY_BYTES   = 2,
  parameter bit PARTIAL_EN   = 1'b1,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          spi_mode_o,
  output logic          native_mode_o,
  output logic          mem_rd_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  input  logic          mem_err_i
);
  mode_e      mode;
  logic       cs_low, byte_valid, phy_miso, active;
  logic [7:0] rx_byte, tx_byte;

  // undecided: listen whatever CS does; SPI: only while selected
  assign active = (mode == MODE_UNSET) || (mode == MODE_SPI && cs_low);

  card_spi_phy u_phy (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sck_i        (sck_i),
    .cs_ni        (cs_ni),
    .mosi_i       (mosi_i),
    .active_i     (active),
    .tx_byte_i    (tx_byte),
    .cs_low_o     (cs_low),
    .byte_valid_o (byte_valid),
    .rx_byte_o    (rx_byte),
    .miso_o       (phy_miso)
  );

  card_spi_ctrl #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .MEM_BYTES    (MEM_BYTES),
    .BUSY_BYTES   (BUSY_BYTES),
    .PARTIAL_EN   (PARTIAL_EN)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_low_i     (cs_low),
    .byte_valid_i (byte_valid),
    .rx_byte_i    (rx_byte),
    .tx_byte_o    (tx_byte),
    .mode_o       (mode),
    .mem_rd_o     (mem_rd_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i),
    .mem_err_i    (mem_err_i)
  );

  assign miso_o        = (mode == MODE_SPI && cs_low) ? phy_miso : 1'b1;
  assign spi_mode_o    = (mode == MODE_SPI);
  assign native_mode_o = (mode == MODE_NATIVE);

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_mode_o |-> miso_o);
endmodule

// File: tb/tb_card_spi_frontend.sv
`timescale 1ns/1ps
module tb_card_spi_frontend;
  localparam int SECTOR = 8;
  localparam int MEMB   = 64;
  localparam int BUSY   = 2;
  localparam int HALF   = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b1;
  logic miso, spi_mode, native_mode, mem_rd, mem_we, mem_err;
  logic [5:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [MEMB];
  int fault_addr = -1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  card_spi_frontend #(.SECTOR_BYTES(SECTOR), .MEM_BYTES(MEMB),
                      .BUSY_BYTES(BUSY), .PARTIAL_EN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .spi_mode_o(spi_mode), .native_mode_o(native_mode),
    .mem_rd_o(mem_rd), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err));

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr];
      mem_err   <= (int'(mem_addr) == fault_addr);
    end
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  // scoreboard: expected MISO bytes, popped by the monitor
  typedef struct { bit chk; logic [7:0] exp; int req; } exp_t;
  exp_t q[$];
  int mon_n = 0;
  logic [7:0] mon_sh;

  always @(posedge sck) begin
    mon_sh = {mon_sh[6:0], miso};
    mon_n++;
    if (mon_n == 8) begin
      mon_n = 0;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.chk) begin
          checks++;
          if (mon_sh !== e.exp) begin
            fails++;
            $display("FAIL R%0d miso byte act=%02h exp=%02h", e.req, mon_sh, e.exp);
          end
        end
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input int req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b);
    mosi = b;
    wclk(HALF); sck = 1'b1;
    wclk(HALF); sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, input bit chk, input logic [7:0] exp, input int req);
    q.push_back('{chk, exp, req});
    for (int i = 7; i >= 0; i--) spi_bit(tx[i]);
  endtask

  task automatic sel();
    wclk(HALF); cs_n = 1'b0; mon_n = 0; wclk(HALF);
  endtask

  task automatic desel();
    wclk(HALF); cs_n = 1'b1; mosi = 1'b1; wclk(2*HALF);
  endtask

  task automatic frame(input logic [5:0] idx, input logic [31:0] arg, input bit chk, input int req);
    xfer({2'b01, idx}, chk, 8'hFF, req);
    xfer(arg[31:24], chk, 8'hFF, req);
    xfer(arg[23:16], chk, 8'hFF, req);
    xfer(arg[15:8],  chk, 8'hFF, req);
    xfer(arg[7:0],   chk, 8'hFF, req);
    xfer(8'h95,      chk, 8'hFF, req);
  endtask

  // frame bytes read idle (R4), then the R1 byte right after
  task automatic cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] r1, input int req);
    frame(idx, arg, 1'b1, 4);
    xfer(8'hFF, 1'b1, r1, req);
  endtask

  task automatic por();
    rst_ni = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b1;
    wclk(5); mon_n = 0; q.delete();
    rst_ni = 1'b1; wclk(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEMB; i++) mem[i] = 8'(i * 7 + 3);
    por();
    // R1 reset state
    check(!spi_mode && !native_mode, 1, {spi_mode, native_mode}, 0);
    check(miso === 1'b1 && !mem_rd && !mem_we, 1, miso, 1);

    // R3 first reset frame with CS high: silent, native latched
    frame(6'd0, 32'd0, 1'b1, 3);
    xfer(8'hFF, 1'b1, 8'hFF, 3);
    xfer(8'hFF, 1'b1, 8'hFF, 3);
    wclk(4);
    check(native_mode && !spi_mode, 3, {spi_mode, native_mode}, 1);
    // R3 later CS-low reset frame ignored
    sel(); frame(6'd0, 32'd0, 1'b1, 3); xfer(8'hFF, 1'b1, 8'hFF, 3); desel();
    check(native_mode && !spi_mode, 3, {spi_mode, native_mode}, 1);

    por();
    // R2 CS-low reset frame enters SPI mode, answers 0x01
    sel(); cmd(6'd0, 32'd0, 8'h01, 2); xfer(8'hFF, 1'b1, 8'hFF, 4); desel();
    check(spi_mode && !native_mode, 2, {spi_mode, native_mode}, 2);

    // R5 unsupported index
    sel(); cmd(6'd5, 32'd0, 8'h05, 5); desel();

    // R4 partial byte then reselect: alignment restarts; R6 init clears idle
    sel(); spi_bit(1'b0); spi_bit(1'b1); spi_bit(1'b0); desel();
    sel(); cmd(6'd1, 32'd0, 8'h00, 6); desel();
    sel(); cmd(6'd5, 32'd0, 8'h04, 6); desel();

    // R7 full-sector read
    sel(); cmd(6'd17, 32'd10, 8'h00, 7);
    xfer(8'hFF, 1'b1, 8'hFE, 7);
    for (int i = 0; i < SECTOR; i++) xfer(8'hFF, 1'b1, mem[10+i], 7);
    xfer(8'hFF, 1'b1, 8'hFF, 7);
    desel();

    // R10 partial length, then read ending at last address
    sel(); cmd(6'd16, 32'd3, 8'h00, 10); desel();
    sel(); cmd(6'd16, 32'd0, 8'h40, 10); desel();
    sel(); cmd(6'd16, 32'd9, 8'h40, 10); desel();
    sel(); cmd(6'd17, 32'd61, 8'h00, 10);
    xfer(8'hFF, 1'b1, 8'hFE, 10);
    for (int i = 0; i < 3; i++) xfer(8'hFF, 1'b1, mem[61+i], 10);
    xfer(8'hFF, 1'b1, 8'hFF, 10);
    desel();

    // R11 overrun by one byte
    sel(); cmd(6'd17, 32'd62, 8'h20, 11);
    xfer(8'hFF, 1'b1, 8'hFF, 11); xfer(8'hFF, 1'b1, 8'hFF, 11); desel();
    sel(); cmd(6'd24, 32'd62, 8'h20, 11);
    xfer(8'hFE, 1'b1, 8'hFF, 11); xfer(8'hAA, 1'b1, 8'hFF, 11);
    xfer(8'hAA, 1'b1, 8'hFF, 11); desel();
    check(mem[62] == 8'(62*7+3) && mem[63] == 8'(63*7+3), 11, mem[62], 8'(62*7+3));

    // R8 read fault -> error token, no data
    fault_addr = 20;
    sel(); cmd(6'd17, 32'd20, 8'h00, 8);
    xfer(8'hFF, 1'b1, 8'h02, 8);
    xfer(8'hFF, 1'b1, 8'hFF, 8); xfer(8'hFF, 1'b1, 8'hFF, 8); desel();
    fault_addr = -1;

    // R9 write, token, busy, then read back
    sel(); cmd(6'd24, 32'd30, 8'h00, 9);
    xfer(8'hFE, 1'b1, 8'hFF, 9);
    xfer(8'hA1, 1'b1, 8'hFF, 9); xfer(8'hB2, 1'b1, 8'hFF, 9); xfer(8'hC3, 1'b1, 8'hFF, 9);
    xfer(8'h12, 1'b1, 8'hFF, 9); xfer(8'h34, 1'b1, 8'hFF, 9);
    xfer(8'hFF, 1'b1, 8'h05, 9);
    for (int i = 0; i < BUSY; i++) xfer(8'hFF, 1'b1, 8'h00, 9);
    xfer(8'hFF, 1'b1, 8'hFF, 9);
    desel();
    check(mem[30] == 8'hA1 && mem[31] == 8'hB2 && mem[32] == 8'hC3, 9, mem[31], 8'hB2);
    check(mem[33] == 8'(33*7+3), 9, mem[33], 8'(33*7+3));
    sel(); cmd(6'd17, 32'd30, 8'h00, 9);
    xfer(8'hFF, 1'b1, 8'hFE, 9);
    xfer(8'hFF, 1'b1, 8'hA1, 9); xfer(8'hFF, 1'b1, 8'hB2, 9); xfer(8'hFF, 1'b1, 8'hC3, 9);
    desel();

    // R3 reset frame in SPI mode keeps SPI
    sel(); cmd(6'd0, 32'd0, 8'h01, 3); desel();
    check(spi_mode && !native_mode, 3, {spi_mode, native_mode}, 2);

    wclk(20);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule